// File: doc/BRIEF.md
# Butterfly Path-Matrix Control Generator

This block turns a candidate routing for a back-to-back butterfly permutation network into the multiplexer select bits that the network needs. It also checks that routing for collisions. The network has N = 2^LG lanes and 2·LG−1 multiplexer stages. The routing is given as one path per row. A path lists 2·LG lane indices: the lane where the datum enters, then the lane it occupies after each stage, with the last entry being its output lane. The block works out, for every row and stage, whether the datum stays on its lane or crosses to the paired lane. It also reports whether any two paths share a lane at the same position, and whether any step is one the wiring cannot make.

A load begins with a one-cycle `start_i` pulse. Rows then stream in over a valid/ready interface. The producer raises `row_valid_i` with a row on `row_path_i` and must hold both until it sees `row_ready_o` high at a rising edge. That edge is the one at which the row is taken. `row_ready_o` is low outside a load and in any cycle where `start_i` is high, so the producer is stalled until a load is open. Gaps in `row_valid_i` during a load are allowed. After the N-th row is taken, `done_o` pulses and the results stay on the outputs until the next start. Finding a valid path set is left to software outside this block.

Top module: `bbn_ctrl_gen`

## Requirements
- R1: After reset, `ctrl_o` is all zero, `conflict_o`, `bad_hop_o` and `done_o` are low, and `row_ready_o` is low.
- R2: A `start_i` pulse is honoured in any state, including in the middle of a load. At the next edge it clears `ctrl_o` and both flags and opens a new load. `row_ready_o` is low while `start_i` is high and high from the following cycle until the load's N rows are taken.
- R3: A row is taken only at an edge where `row_valid_i` and `row_ready_o` are both high. The k-th row taken in a load (k = 0..N−1) becomes control row k. Idle cycles between rows do not change the result.
- R4: Path position p sits at `row_path_i[p*LG +: LG]`. Position 0 is the input lane and position 2·LG−1 is the output lane. For row i and stage j (0..2·LG−2), bit `ctrl_o[i*(2*LG-1) + j]` is 0 when positions j and j+1 hold the same lane and 1 otherwise.
- R5: `done_o` is high for exactly one cycle, the cycle after the N-th row is taken. `row_ready_o` is low in that cycle.
- R6: `conflict_o` is set if two rows taken in the current load hold the same lane at the same position, checked over all 2·LG positions. Once set, it stays set until the next start.
- R7: Stage j pairs lane k with lane k XOR 2^(LG−1−j) for j < LG, and with lane k XOR 2^(j−LG+1) for j ≥ LG. `bad_hop_o` is set if any row taken in the load steps from position j to j+1 to a lane that is neither the same lane nor the paired lane. Once set, it stays set until the next start.
- R8: Outside a load, `row_valid_i` and `row_path_i` have no effect. `ctrl_o`, `conflict_o` and `bad_hop_o` hold their values until the next start.
- R9: With LG = 2, the four rows (3,3,3,1), (2,0,1,3), (1,1,0,0), (0,2,2,2), listed from position 0, give no conflict and no bad hop. The control rows are 0,0,1 / 1,1,1 / 0,1,0 / 1,0,0 for stages 0,1,2, so `ctrl_o` = 12'h2BC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new load and clears results |
| row_valid_i | input | 1 | A path row is offered on `row_path_i` |
| row_ready_o | output | 1 | Block can take a row this cycle |
| row_path_i | input | 2*LG*LG | One path: 2·LG lane indices of LG bits each |
| done_o | output | 1 | One-cycle pulse after the last row |
| ctrl_o | output | N*(2*LG-1) | Select bits, row-major, stage j of row i at bit i*(2*LG-1)+j |
| conflict_o | output | 1 | Two paths share a lane at one position |
| bad_hop_o | output | 1 | A path makes a step the wiring cannot make |

## Verification
The bench runs a four-lane instance and offers every possible 8-bit row as the first row of a load. The other rows are XOR-shifted copies of it, so these loads are conflict-free by construction while still covering every hop pattern. A design with a wrong stage pairing would raise the illegal-step flag on legal rows, or miss it on illegal ones. A further sweep loads consecutive row codes, which repeat lanes at most positions; a collision check that skipped the input or output column, or forgot a set bit, would miss those repeats. Separate cases cover a start in the middle of a load, which must discard the stale rows and flags, rows offered before a load opens, which a design ignoring ready would latch, and idle gaps between rows, which a design counting cycles instead of handshakes would mis-place.

// File: rtl/bbn_pkg.sv
package bbn_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;

  // Bit of the lane index a stage may flip: the forward half narrows the
  // pair distance from N/2 down to 1, the mirrored half widens it again.
  function automatic int flip_bit(input int lg, input int stage);
    return (stage < lg) ? (lg - 1 - stage) : (stage - lg + 1);
  endfunction

endpackage

// File: rtl/bbn_hop_eval.sv
module bbn_hop_eval #(
  parameter int LG = 3
) (
  input  logic [2*LG*LG-1:0] path_i,
  output logic [2*LG-2:0]    sel_o,
  output logic               hop_bad_o
);
  import bbn_pkg::*;

  localparam int STAGES = 2 * LG - 1;

  logic [STAGES-1:0] step_ok;

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    localparam int FB = flip_bit(LG, j);
    localparam logic [LG-1:0] FLIP = LG'(1) << FB;
    logic [LG-1:0] here, next;
    assign here       = path_i[j*LG +: LG];
    assign next       = path_i[(j+1)*LG +: LG];
    assign sel_o[j]   = (here != next);
    assign step_ok[j] = (here == next) || (next == (here ^ FLIP));
  end

  assign hop_bad_o = ~&step_ok;

  // A path that never leaves its lane cannot make an illegal step.
  always_comb begin
    if (sel_o == '0) begin
      p_straight_path_legal_r7 : assert (!hop_bad_o);
    end
  end

endmodule

// File: rtl/bbn_lane_tracker.sv
module bbn_lane_tracker #(
  parameter int LG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               acc_i,
  input  logic [2*LG*LG-1:0] path_i,
  output logic               hit_o
);
  localparam int N    = 1 << LG;
  localparam int COLS = 2 * LG;

  logic [COLS-1:0] col_hit;

  for (genvar p = 0; p < COLS; p++) begin : g_col
    logic [N-1:0]  occ_q;
    logic [LG-1:0] lane;
    assign lane       = path_i[p*LG +: LG];
    assign col_hit[p] = acc_i && occ_q[lane];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q <= '0;
      end else if (clear_i) begin
        occ_q <= '0;
      end else if (acc_i) begin
        occ_q[lane] <= 1'b1;
      end
    end

    // A fresh lane adds exactly one occupied slot in its column.
    p_fresh_lane_fills_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !clear_i && !col_hit[p]) |=>
        ($countones(occ_q) == $past($countones(occ_q)) + 1));

    p_start_empties_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (occ_q == '0));
  end

  assign hit_o = |col_hit;

endmodule

// File: rtl/bbn_load_seq.sv
module bbn_load_seq #(
  parameter int N  = 8,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic [RW-1:0] row_o,
  output logic          done_o
);
  import bbn_pkg::*;

  seq_state_t    st_q;
  logic [RW-1:0] cnt_q;
  logic          last_row;

  assign ready_o  = (st_q == SEQ_LOAD) && !start_i;
  assign accept_o = ready_o && valid_i;
  assign last_row = (cnt_q == RW'(N - 1));
  assign row_o    = cnt_q;
  assign done_o   = (st_q == SEQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      st_q  <= SEQ_LOAD;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_LOAD: begin
          if (accept_o) begin
            if (last_row) begin
              st_q  <= SEQ_DONE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SEQ_DONE: st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  p_done_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_last_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && last_row) |=> done_o);

  p_open_after_start_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ready_o || start_i));

endmodule

// File: rtl/bbn_ctrl_store.sv
module bbn_ctrl_store #(
  parameter int N  = 8,
  parameter int S  = 5,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [RW-1:0] row_i,
  input  logic [S-1:0]  bits_i,
  output logic [N*S-1:0] mat_o
);
  for (genvar r = 0; r < N; r++) begin : g_row
    logic [S-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (clear_i) begin
        row_q <= '0;
      end else if (wr_i && (row_i == RW'(r))) begin
        row_q <= bits_i;
      end
    end
    assign mat_o[r*S +: S] = row_q;
  end

endmodule

// File: rtl/bbn_ctrl_gen.sv
module bbn_ctrl_gen #(
  parameter int LG = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         row_valid_i,
  output logic                         row_ready_o,
  input  logic [2*LG*LG-1:0]           row_path_i,
  output logic                         done_o,
  output logic [(1<<LG)*(2*LG-1)-1:0]  ctrl_o,
  output logic                         conflict_o,
  output logic                         bad_hop_o
);
  localparam int N  = 1 << LG;
  localparam int S  = 2 * LG - 1;
  localparam int RW = LG;

  logic          accept;
  logic [RW-1:0] row_idx;
  logic [S-1:0]  row_sel;
  logic          hop_bad;
  logic          lane_hit;

  bbn_load_seq #(.N(N), .RW(RW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .valid_i  (row_valid_i),
    .ready_o  (row_ready_o),
    .accept_o (accept),
    .row_o    (row_idx),
    .done_o   (done_o)
  );

  bbn_hop_eval #(.LG(LG)) u_hop (
    .path_i    (row_path_i),
    .sel_o     (row_sel),
    .hop_bad_o (hop_bad)
  );

  bbn_lane_tracker #(.LG(LG)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .acc_i   (accept),
    .path_i  (row_path_i),
    .hit_o   (lane_hit)
  );

  bbn_ctrl_store #(.N(N), .S(S), .RW(RW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .wr_i    (accept),
    .row_i   (row_idx),
    .bits_i  (row_sel),
    .mat_o   (ctrl_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_o <= 1'b0;
      bad_hop_o  <= 1'b0;
    end else if (start_i) begin
      conflict_o <= 1'b0;
      bad_hop_o  <= 1'b0;
    end else if (accept) begin
      conflict_o <= conflict_o | lane_hit;
      bad_hop_o  <= bad_hop_o | hop_bad;
    end
  end

  p_start_clears_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((ctrl_o == '0) && !conflict_o && !bad_hop_o));

  p_hold_when_closed_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!row_ready_o && !start_i) |=>
      ($stable(ctrl_o) && $stable(conflict_o) && $stable(bad_hop_o)));

  p_conflict_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_o && !start_i) |=> conflict_o);

  p_bad_hop_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (bad_hop_o && !start_i) |=> bad_hop_o);

  p_closed_at_done_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !row_ready_o);

endmodule

// File: tb/sim_bbn_ctrl_gen.sv
module sim_bbn_ctrl_gen;
  localparam int LG = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        row_valid = 1'b0;
  logic [7:0]  row_path = '0;
  logic        row_ready;
  logic        done;
  logic [11:0] ctrl;
  logic        conflict;
  logic        bad_hop;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bbn_ctrl_gen #(.LG(LG)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .row_valid_i (row_valid),
    .row_ready_o (row_ready),
    .row_path_i  (row_path),
    .done_o      (done),
    .ctrl_o      (ctrl),
    .conflict_o  (conflict),
    .bad_hop_o   (bad_hop)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R4: select bit per stage from adjacent positions
  function automatic logic [2:0] exp_sel(input logic [7:0] v);
    logic [2:0] s;
    for (int j = 0; j < 3; j++) s[j] = (v[j*2 +: 2] != v[(j+1)*2 +: 2]);
    return s;
  endfunction

  // R7: pair distance 2,1,2 for stages 0,1,2 when LG = 2
  function automatic bit exp_bad(input logic [7:0] v);
    bit b = 1'b0;
    for (int j = 0; j < 3; j++) begin
      logic [1:0] a = v[j*2 +: 2];
      logic [1:0] n = v[(j+1)*2 +: 2];
      logic [1:0] d = (j == 1) ? 2'd1 : 2'd2;
      if (!(n == a || n == (a ^ d))) b = 1'b1;
    end
    return b;
  endfunction

  // R6: any repeated lane in any of the four positions
  function automatic bit exp_conf(input logic [31:0] rows);
    bit c = 1'b0;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 4; i++)
        for (int k = i + 1; k < 4; k++)
          if (rows[i*8 + p*2 +: 2] == rows[k*8 + p*2 +: 2]) c = 1'b1;
    return c;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    #1 check("R2 ready low during start", row_ready, 0);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_row(input logic [7:0] v);
    @(negedge clk); row_valid = 1'b1; row_path = v;
    #1;
    while (!row_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    row_valid = 1'b0;
  endtask

  task automatic run_load(input logic [31:0] rows, input int gap, input string tag);
    logic [11:0] ec;
    bit eb = 1'b0;
    do_start();
    for (int k = 0; k < 4; k++) begin
      send_row(rows[k*8 +: 8]);
      ec[k*3 +: 3] = exp_sel(rows[k*8 +: 8]);
      eb = eb | exp_bad(rows[k*8 +: 8]);
      if (k < 3) repeat (gap) @(negedge clk);
    end
    check({tag, " R5 done"}, done, 1);
    check({tag, " R5 ready low at done"}, row_ready, 0);
    check({tag, " R4 R3 ctrl"}, ctrl, ec);
    check({tag, " R6 conflict"}, conflict, exp_conf(rows));
    check({tag, " R7 bad hop"}, bad_hop, eb);
    @(negedge clk); @(posedge clk); #1;
    check({tag, " R5 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rows;
    logic [11:0] held;
    repeat (3) @(negedge clk);
    #1;
    check("R1 ctrl after reset", ctrl, 0);
    check("R1 conflict after reset", conflict, 0);
    check("R1 bad hop after reset", bad_hop, 0);
    check("R1 done after reset", done, 0);
    check("R1 ready after reset", row_ready, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 ready idle", row_ready, 0);

    // R9: documented conflict-free example
    rows = {8'hA8, 8'h05, 8'hD2, 8'h7F};
    run_load(rows, 0, "R9 example");
    check("R9 ctrl literal", ctrl, 12'h2BC);

    // R8: rows offered while closed change nothing
    held = ctrl;
    @(negedge clk); row_valid = 1'b1; row_path = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R8 ctrl held", ctrl, held);
    check("R8 conflict held", conflict, 0);
    check("R8 bad hop held", bad_hop, 0);
    check("R3 ready stays low", row_ready, 0);
    // R3: held row is taken only once the load opens
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1 check("R3 ready opens", row_ready, 1);
    @(posedge clk); #1; row_valid = 1'b0;
    @(negedge clk); #1;
    check("R3 stalled row taken as row 0", ctrl, 12'h000);
    check("R6 single row no conflict", conflict, 0);
    // R2: restart mid-load with a conflicting, illegal row
    send_row(8'h01);
    @(negedge clk); #1;
    check("R6 repeat lane flagged", conflict, 1);
    check("R7 illegal step flagged", bad_hop, 1);
    rows = {8'h1B, 8'hB1, 8'h4E, 8'hE4};
    run_load(rows, 2, "R2 restart");

    // Exhaustive row sweep, conflict-free sets (XOR shifted copies)
    for (int b = 0; b < 256; b++) begin
      logic [7:0] base = 8'(b);
      rows = {base ^ 8'hFF, base ^ 8'hAA, base ^ 8'h55, base};
      run_load(rows, b % 3, "R4 R7 sweep");
    end

    // Consecutive codes, mostly conflicting sets
    for (int g = 0; g < 64; g++) begin
      rows = {8'(4*g+3), 8'(4*g+2), 8'(4*g+1), 8'(4*g)};
      run_load(rows, 1, "R6 sweep");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule